// File: doc/BRIEF.md
# Key-Protected Clock Control Register

This block holds the clock configuration byte for a small chip. The byte contains five enables and a three-bit system clock source code. It sits at one fixed address on an 8-bit peripheral bus with 12-bit addresses. The enables cover the internal precision oscillator, the crystal oscillator and the watchdog oscillator, plus failure detection for the system clock and for the watchdog oscillator. Its outputs go straight to the clock generation logic.

Stray software cannot change the clock setup, because the register accepts data only after a two-byte key. The key is E7h and then 18h, both written to the register's own address. Exactly one data write is then accepted, and the register seals itself again. Software can therefore disable every clock source, so only the power-on reset restores the default value, and it does so at any time.

The crystal enable also takes priority over the general-purpose control of the two crystal pins.

Top module: `clkctl_guard`

## Requirements
- R1: After power-on reset, the register reads A0h and `unlocked` is 0. At A0h, `int_osc_en`=1, `wdt_osc_en`=1, all other enables are 0 and `clk_src_sel`=000.
- R2: A write to address F86h while the register is locked does not change the stored value.
- R3: Writing E7h and then 18h to F86h sets `unlocked` to 1. The next write to F86h is stored, with this bit mapping: bit 7 `int_osc_en`, bit 6 `xtal_en`, bit 5 `wdt_osc_en`, bit 4 `sysclk_fail_det_en`, bit 3 `wdt_fail_det_en`, bits 2:0 `clk_src_sel`.
- R4: `unlocked` returns to 0 after one accepted data write. A second write then has no effect.
- R5: After E7h, any second byte other than 18h, including E7h, returns the sequence to its start. The wrong byte is not stored, and a following 18h alone does not unlock.
- R6: A write to any other address between the two key bytes abandons the sequence.
- R7: With `bus_rd`=1 and address F86h, `bus_rdata` shows the stored byte. Otherwise `bus_rdata` is 00h. Reads never change `unlocked`.
- R8: Writes to other addresses never change the register. While unlocked, they do not consume the unlock.
- R9: Each bit of `gpio_pin_grant` equals the matching bit of `gpio_pin_req` when `xtal_en`=0, and is 0 when `xtal_en`=1.
- R10: Asserting `por_n` low restores A0h and the locked state from any state. This includes the state in which every source is disabled.
- R11: The key bytes are never stored, and `unlocked` reports the open state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_addr | input | 12 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 00h unless this register is read |
| int_osc_en | output | 1 | Internal precision oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| wdt_osc_en | output | 1 | Watchdog oscillator enable |
| sysclk_fail_det_en | output | 1 | System clock failure detection enable |
| wdt_fail_det_en | output | 1 | Watchdog oscillator failure detection enable |
| clk_src_sel | output | 3 | System clock source code |
| gpio_pin_req | input | 2 | General-purpose control request for the two crystal pins |
| gpio_pin_grant | output | 2 | Request passed through unless the crystal owns the pins |
| unlocked | output | 1 | High while one data write will be accepted |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that each strobe covers a single transfer. The assertion that reads leave the lock unchanged relies on this. The bench drives exactly one operation per clock, raised at the falling edge. It never combines a read with a write, so all stimulus stays inside those assumptions. The power-on reset is pulsed only between operations.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        LK_SEALED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic       int_osc_en;
        logic       xtal_en;
        logic       wdt_osc_en;
        logic       sysclk_fd_en;
        logic       wdt_fd_en;
        logic [2:0] clk_sel;
    } ctl_fields_t;

endpackage

// File: rtl/clkctl_key_fsm.sv
module clkctl_key_fsm
    import clkctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = 8'hE7,
    parameter logic [DATA_W-1:0] KEY_B = 8'h18
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hit_wr,
    input  logic              miss_wr,
    input  logic              hit_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic              unlocked
);

    typedef struct packed {
        lock_state_e st;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic commit_d;

    always_comb begin
        nxt_d    = cur_q;
        commit_d = 1'b0;
        unique case (cur_q.st)
            LK_SEALED: begin
                if (hit_wr && wdata == KEY_A) nxt_d.st = LK_HALF;
            end
            LK_HALF: begin
                if (hit_wr) begin
                    nxt_d.st = (wdata == KEY_B) ? LK_OPEN : LK_SEALED;
                end else if (miss_wr) begin
                    nxt_d.st = LK_SEALED;
                end
            end
            LK_OPEN: begin
                if (hit_wr) begin
                    commit_d = 1'b1;
                    nxt_d.st = LK_SEALED;
                end
            end
            default: nxt_d.st = LK_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cur_q <= '{st: LK_SEALED};
        else        cur_q <= nxt_d;
    end

    assign commit   = commit_d;
    assign unlocked = (cur_q.st == LK_OPEN);

    AST_KEY_A_ADVANCES: assert property (@(posedge clk) disable iff (!por_n)
        (cur_q.st == LK_SEALED && hit_wr && wdata == KEY_A) |=> (cur_q.st == LK_HALF)); // R3
    AST_ONE_SHOT_RELOCK: assert property (@(posedge clk) disable iff (!por_n)
        commit |=> !unlocked); // R4
    AST_BAD_SECOND_RESETS: assert property (@(posedge clk) disable iff (!por_n)
        (cur_q.st == LK_HALF && hit_wr && wdata != KEY_B) |=> (cur_q.st == LK_SEALED)); // R5
    AST_FOREIGN_ABANDONS: assert property (@(posedge clk) disable iff (!por_n)
        (cur_q.st == LK_HALF && miss_wr) |=> (cur_q.st == LK_SEALED)); // R6
    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(unlocked) |-> ($past(cur_q.st) == LK_HALF && $past(hit_wr))); // R11
    AST_READ_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!por_n)
        (hit_rd && !hit_wr && !miss_wr) |=> $stable(unlocked)); // R7
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!por_n)
        !(hit_rd && (hit_wr || miss_wr))); // R7

endmodule

// File: rtl/clkctl_reg_store.sv
module clkctl_reg_store
    import clkctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = 8'hA0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } store_t;

    store_t reg_q, reg_d;

    always_comb begin
        reg_d = reg_q;
        if (commit) reg_d.val = wdata;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) reg_q <= '{val: RESET_VAL};
        else        reg_q <= reg_d;
    end

    assign value = reg_q.val;

    AST_HOLD_WHILE_SEALED: assert property (@(posedge clk) disable iff (!por_n)
        !commit |=> $stable(value)); // R2
    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!por_n)
        commit |=> (value == $past(wdata))); // R3

endmodule

// File: rtl/clkctl_guard.sv
module clkctl_guard
    import clkctl_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 12'hF86,
    parameter logic [DATA_W-1:0] KEY_A     = 8'hE7,
    parameter logic [DATA_W-1:0] KEY_B     = 8'h18,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'hA0,
    parameter int                XPIN_N    = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              int_osc_en,
    output logic              xtal_en,
    output logic              wdt_osc_en,
    output logic              sysclk_fail_det_en,
    output logic              wdt_fail_det_en,
    output logic [2:0]        clk_src_sel,
    input  logic [XPIN_N-1:0] gpio_pin_req,
    output logic [XPIN_N-1:0] gpio_pin_grant,
    output logic              unlocked
);

    logic              addr_hit;
    logic              hit_wr, miss_wr, hit_rd;
    logic              commit;
    logic [DATA_W-1:0] value;
    ctl_fields_t       fields;

    always_comb begin
        addr_hit = (bus_addr == REG_ADDR);
        hit_wr   = bus_wr &  addr_hit;
        miss_wr  = bus_wr & ~addr_hit;
        hit_rd   = bus_rd &  addr_hit;
    end

    clkctl_key_fsm #(
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) i_key_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .hit_wr   (hit_wr),
        .miss_wr  (miss_wr),
        .hit_rd   (hit_rd),
        .wdata    (bus_wdata),
        .commit   (commit),
        .unlocked (unlocked)
    );

    clkctl_reg_store #(
        .RESET_VAL (RESET_VAL)
    ) i_reg_store (
        .clk    (clk),
        .por_n  (por_n),
        .commit (commit),
        .wdata  (bus_wdata),
        .value  (value)
    );

    always_comb begin
        fields             = ctl_fields_t'(value);
        int_osc_en         = fields.int_osc_en;
        xtal_en            = fields.xtal_en;
        wdt_osc_en         = fields.wdt_osc_en;
        sysclk_fail_det_en = fields.sysclk_fd_en;
        wdt_fail_det_en    = fields.wdt_fd_en;
        clk_src_sel        = fields.clk_sel;
        bus_rdata          = hit_rd ? value : '0;
    end

    for (genvar p = 0; p < XPIN_N; p++) begin : g_pin
        assign gpio_pin_grant[p] = gpio_pin_req[p] & ~fields.xtal_en;
    end

    AST_XTAL_OWNS_PINS: assert property (@(posedge clk) disable iff (!por_n)
        xtal_en |-> (gpio_pin_grant == '0)); // R9
    AST_OTHER_ADDR_NO_EFFECT: assert property (@(posedge clk) disable iff (!por_n)
        miss_wr |=> $stable(value)); // R8
    AST_OPEN_SURVIVES_FOREIGN: assert property (@(posedge clk) disable iff (!por_n)
        (unlocked && !hit_wr) |=> unlocked); // R8

endmodule

// File: tb/test_clkctl_guard.sv
module test_clkctl_guard;

    logic        clk = 1'b0;
    logic        por_n;
    logic [11:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        int_osc_en, xtal_en, wdt_osc_en, sysclk_fail_det_en, wdt_fail_det_en;
    logic [2:0]  clk_src_sel;
    logic [1:0]  gpio_pin_req, gpio_pin_grant;
    logic        unlocked;

    int vec_cnt  = 0;
    int miss_cnt = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    clkctl_guard i_clkctl_guard (
        .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_osc_en(int_osc_en),
        .xtal_en(xtal_en), .wdt_osc_en(wdt_osc_en), .sysclk_fail_det_en(sysclk_fail_det_en),
        .wdt_fail_det_en(wdt_fail_det_en), .clk_src_sel(clk_src_sel),
        .gpio_pin_req(gpio_pin_req), .gpio_pin_grant(gpio_pin_grant), .unlocked(unlocked)
    );

    // vector: op(2: 1=write, 2=read) addr(12) data(8) expected rdata(8) expected unlocked(1)
    localparam int NV = 24;
    localparam logic [30:0] VEC [NV] = '{
        {2'd2, 12'hF86, 8'h00, 8'hA0, 1'b0},  // 0  R1 reset value
        {2'd1, 12'hF86, 8'h55, 8'h00, 1'b0},  // 1  R2 locked write
        {2'd2, 12'hF86, 8'h00, 8'hA0, 1'b0},  // 2  R2 unchanged
        {2'd1, 12'hF86, 8'hE7, 8'h00, 1'b0},  // 3  R3 key A
        {2'd1, 12'hF86, 8'h18, 8'h00, 1'b1},  // 4  R3 key B opens
        {2'd2, 12'hF86, 8'h00, 8'hA0, 1'b1},  // 5  R11/R7 key not stored, read keeps open
        {2'd1, 12'hF86, 8'h5B, 8'h00, 1'b0},  // 6  R4 data accepted, relocks
        {2'd2, 12'hF86, 8'h00, 8'h5B, 1'b0},  // 7  R3 stored
        {2'd1, 12'hF86, 8'h3C, 8'h00, 1'b0},  // 8  R4 second write
        {2'd2, 12'hF86, 8'h00, 8'h5B, 1'b0},  // 9  R4 ignored
        {2'd1, 12'hF86, 8'hE7, 8'h00, 1'b0},  // 10 R5
        {2'd1, 12'hF86, 8'h19, 8'h00, 1'b0},  // 11 R5 wrong second byte
        {2'd1, 12'hF86, 8'h18, 8'h00, 1'b0},  // 12 R5 lone key B
        {2'd2, 12'hF86, 8'h00, 8'h5B, 1'b0},  // 13 R5 nothing stored
        {2'd1, 12'hF86, 8'hE7, 8'h00, 1'b0},  // 14 R6
        {2'd1, 12'hF87, 8'h18, 8'h00, 1'b0},  // 15 R6 foreign write
        {2'd1, 12'hF86, 8'h18, 8'h00, 1'b0},  // 16 R6 sequence abandoned
        {2'd2, 12'hF86, 8'h00, 8'h5B, 1'b0},  // 17 R6
        {2'd1, 12'hF86, 8'hE7, 8'h00, 1'b0},  // 18
        {2'd1, 12'hF86, 8'h18, 8'h00, 1'b1},  // 19 R3
        {2'd1, 12'hF85, 8'hAA, 8'h00, 1'b1},  // 20 R8 foreign write keeps open
        {2'd2, 12'hF85, 8'h00, 8'h00, 1'b1},  // 21 R7 other address reads 0
        {2'd1, 12'hF86, 8'h00, 8'h00, 1'b0},  // 22 R10 all disabled
        {2'd2, 12'hF86, 8'h00, 8'h00, 1'b0}   // 23 R8 stored 00, not AA
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [11:0] a, input logic [7:0] d,
                         input logic [7:0] exp_rd, input logic exp_unl, input string req);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = (op == 2'd1);
        bus_rd    = (op == 2'd2);
        #1;
        if (op == 2'd2) chk({req, " rdata"}, 32'(bus_rdata), 32'(exp_rd));
        @(posedge clk);
        #1;
        chk({req, " unlocked"}, 32'(unlocked), 32'(exp_unl));
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            miss_cnt++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        por_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        gpio_pin_req = 2'b11;
        #12;
        // R1 outputs in reset state
        chk("R1 fields", 32'({int_osc_en, xtal_en, wdt_osc_en, sysclk_fail_det_en,
                              wdt_fail_det_en, clk_src_sel}), 32'h A0);
        chk("R1 unlocked", 32'(unlocked), 32'h0);
        chk("R9 grant xtal off", 32'(gpio_pin_grant), 32'h3);
        @(negedge clk);
        por_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][30:29], VEC[i][28:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0],
                  $sformatf("vec%0d", i));
        end

        // R3 bit mapping: C6 = 1100_0110
        wr(12'hF86, 8'hE7); wr(12'hF86, 8'h18); wr(12'hF86, 8'hC6);
        #1;
        chk("R3 int_osc_en", 32'(int_osc_en), 32'h1);
        chk("R3 xtal_en", 32'(xtal_en), 32'h1);
        chk("R3 wdt_osc_en", 32'(wdt_osc_en), 32'h0);
        chk("R3 sysclk_fail_det_en", 32'(sysclk_fail_det_en), 32'h0);
        chk("R3 wdt_fail_det_en", 32'(wdt_fail_det_en), 32'h0);
        chk("R3 clk_src_sel", 32'(clk_src_sel), 32'h6);
        chk("R9 grant xtal on", 32'(gpio_pin_grant), 32'h0);
        gpio_pin_req = 2'b10;
        #1;
        chk("R9 grant xtal on req 10", 32'(gpio_pin_grant), 32'h0);

        // R3 other fields: 1B = 0001_1011
        wr(12'hF86, 8'hE7); wr(12'hF86, 8'h18); wr(12'hF86, 8'h1B);
        #1;
        chk("R3 fields 1B", 32'({int_osc_en, xtal_en, wdt_osc_en, sysclk_fail_det_en,
                                 wdt_fail_det_en, clk_src_sel}), 32'h1B);
        chk("R9 grant pass", 32'(gpio_pin_grant), 32'h2);

        // R5: E7, E7, 18 must not unlock
        wr(12'hF86, 8'hE7); wr(12'hF86, 8'hE7); wr(12'hF86, 8'h18);
        #1;
        chk("R5 double key A", 32'(unlocked), 32'h0);
        apply(2'd2, 12'hF86, 8'h00, 8'h1B, 1'b0, "R5 value kept");

        // R10: POR from the all-disabled state while open
        wr(12'hF86, 8'hE7); wr(12'hF86, 8'h18); wr(12'hF86, 8'h00);
        wr(12'hF86, 8'hE7); wr(12'hF86, 8'h18);
        #1;
        chk("R11 open", 32'(unlocked), 32'h1);
        por_n = 1'b0;
        #1;
        chk("R10 unlocked cleared", 32'(unlocked), 32'h0);
        chk("R10 value restored", 32'({int_osc_en, xtal_en, wdt_osc_en, sysclk_fail_det_en,
                                       wdt_fail_det_en, clk_src_sel}), 32'hA0);
        @(negedge clk);
        por_n = 1'b1;
        apply(2'd1, 12'hF86, 8'h77, 8'h00, 1'b0, "R10 locked after por");
        apply(2'd2, 12'hF86, 8'h00, 8'hA0, 1'b0, "R10 write ignored");

        done = 1'b1;
        finish_run();
    end

endmodule